// File: doc/BRIEF.md
# Branch Target Buffer

This block gives the fetch stage a predicted next PC in the same cycle in which it presents a PC. It is organised as a direct-mapped table. The PC word-address bits just above the byte offset select one entry. Every remaining upper bit is kept as a full tag and compared exactly. Because of this, two branches that share an index can never return each other's target. When the lookup finds a valid, matching entry whose taken bit is set, the stored target is handed back and fetch redirects. In every other case fetch continues at the sequential address, PC + 4.

Writes come only from branch resolution in the execute stage. A branch that resolved taken installs or overwrites its entry with its target and sets the taken bit. A branch that resolved not-taken and finds its own entry clears that entry's taken bit. The lookup is a combinational read of registered state. As a result, a write in a given cycle becomes visible only from the next cycle.

Top module: `btb`

## Requirements
- R1: A synchronous reset, active high, invalidates every entry, so every lookup after it reports no redirect.
- R2: An entry is chosen by PC bits [IDX_W+1:2], and its tag is PC bits [31:IDX_W+2]. A lookup matches only when the entry is valid and its stored tag equals the lookup tag exactly. A PC that shares the index but has a different tag misses.
- R3: PC bits [1:0] play no part in the lookup or in the update. For a lookup they change only the PC + 4 fall-through value.
- R4: On a match whose taken bit is 1, `pred_taken` is 1 and `pred_next_pc` equals the stored target.
- R5: On a miss, or on a match whose taken bit is 0, `pred_taken` is 0 and `pred_next_pc` equals `fetch_pc` + 4, modulo 2^32.
- R6: An update with `upd_valid`=1 and `upd_taken`=1 writes valid=1, the tag of `upd_pc`, `upd_target` and taken=1 into the indexed entry. Any previous contents are replaced, even those of a different tag. The entry answers lookups from the next cycle on.
- R7: An update with `upd_valid`=1 and `upd_taken`=0 whose PC matches its entry clears that entry's taken bit, so later lookups of that PC report no redirect.
- R8: An update with `upd_valid`=1 and `upd_taken`=0 whose PC does not match its entry leaves that entry unchanged.
- R9: A write to the entry being looked up in the same cycle does not change that cycle's lookup result.
- R10: While `upd_valid`=0, the values on `upd_pc`, `upd_taken` and `upd_target` leave the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_pc | input | 32 | PC presented by fetch for lookup |
| upd_valid | input | 1 | A resolved branch is presented on the update port |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_target | input | 32 | Resolved target address |
| pred_taken | output | 1 | A valid, matching entry predicts taken |
| pred_next_pc | output | 32 | Stored target when `pred_taken` is 1, otherwise `fetch_pc` + 4 |

## Verification
The bench builds the block with IDX_W = 3, which gives eight entries and a 27-bit tag. With that size, every entry can be filled, probed and disturbed in a sweep. The sweeps cover each index for install, low-bit insensitivity, alias misses at the same index, the clearing of the taken bit and alias overwrite. A small table also makes the same-cycle collision between a write and a lookup easy to target, and lets a mid-run reset be checked against every entry.

// File: rtl/btb_pkg.sv
package btb_pkg;

    localparam int PC_W    = 32;
    localparam int ALIGN_W = 2;
    localparam int PC_STEP = 4;

    // What the resolve path does to the indexed entry this cycle
    typedef enum logic [1:0] {
        UPD_IDLE       = 2'd0,
        UPD_INSTALL    = 2'd1,
        UPD_DROP_TAKEN = 2'd2
    } upd_op_e;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [PC_W-1:0] target;
        logic            taken;
        logic            valid;
    } resolve_t;

    function automatic logic [PC_W-1:0] seq_pc(input logic [PC_W-1:0] pc);
        return pc + PC_W'(PC_STEP);
    endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int TAG_W = PC_W - IDX_W - ALIGN_W
) (
    input  logic             clk,
    input  logic             rst,
    // read port A: fetch lookup
    input  logic [IDX_W-1:0] a_idx,
    output logic             a_valid,
    output logic [TAG_W-1:0] a_tag,
    output logic [PC_W-1:0]  a_target,
    output logic             a_taken,
    // read port B: resolve-side tag probe
    input  logic [IDX_W-1:0] b_idx,
    output logic             b_valid,
    output logic [TAG_W-1:0] b_tag,
    // write port
    input  upd_op_e          wr_op,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_target
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] taken_q;
    logic [TAG_W-1:0]   tag_q    [ENTRIES];
    logic [PC_W-1:0]    target_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_op == UPD_INSTALL) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst) begin
            case (wr_op)
                UPD_INSTALL: begin
                    taken_q[wr_idx]  <= 1'b1;
                    tag_q[wr_idx]    <= wr_tag;
                    target_q[wr_idx] <= wr_target;
                end
                UPD_DROP_TAKEN: taken_q[wr_idx] <= 1'b0;
                default: ;
            endcase
        end
    end

    assign a_valid  = valid_q[a_idx];
    assign a_tag    = tag_q[a_idx];
    assign a_target = target_q[a_idx];
    assign a_taken  = taken_q[a_idx];
    assign b_valid  = valid_q[b_idx];
    assign b_tag    = tag_q[b_idx];

endmodule

// File: rtl/btb_update_ctl.sv
module btb_update_ctl
    import btb_pkg::*;
#(
    parameter int TAG_W = 24
) (
    input  resolve_t         req,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             ent_valid,
    input  logic [TAG_W-1:0] ent_tag,
    output upd_op_e          op
);
    logic ent_match;
    assign ent_match = ent_valid && (ent_tag == req_tag);

    always_comb begin
        op = UPD_IDLE;
        if (req.valid) begin
            if (req.taken)      op = UPD_INSTALL;
            else if (ent_match) op = UPD_DROP_TAKEN;
        end
    end
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
    import btb_pkg::*;
#(
    parameter int TAG_W = 24
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [TAG_W-1:0] pc_tag,
    input  logic             ent_valid,
    input  logic [TAG_W-1:0] ent_tag,
    input  logic [PC_W-1:0]  ent_target,
    input  logic             ent_taken,
    output logic             redirect,
    output logic [PC_W-1:0]  next_pc
);
    logic tag_hit;
    assign tag_hit  = ent_valid && (ent_tag == pc_tag);
    assign redirect = tag_hit && ent_taken;
    assign next_pc  = redirect ? ent_target : seq_pc(pc);
endmodule

// File: rtl/btb.sv
module btb
    import btb_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] fetch_pc,
    input  logic        upd_valid,
    input  logic [31:0] upd_pc,
    input  logic        upd_taken,
    input  logic [31:0] upd_target,
    output logic        pred_taken,
    output logic [31:0] pred_next_pc
);
    localparam int TAG_W = PC_W - IDX_W - ALIGN_W;
    localparam int TAG_LO = IDX_W + ALIGN_W;

    resolve_t         req;
    logic [IDX_W-1:0] f_idx, u_idx;
    logic [TAG_W-1:0] f_tag, u_tag;
    logic             a_valid, a_taken, b_valid;
    logic [TAG_W-1:0] a_tag, b_tag;
    logic [PC_W-1:0]  a_target;
    upd_op_e          op;

    assign req   = '{pc: upd_pc, target: upd_target, taken: upd_taken, valid: upd_valid};
    assign f_idx = fetch_pc[TAG_LO-1:ALIGN_W];
    assign f_tag = fetch_pc[PC_W-1:TAG_LO];
    assign u_idx = req.pc[TAG_LO-1:ALIGN_W];
    assign u_tag = req.pc[PC_W-1:TAG_LO];

    btb_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst(rst),
        .a_idx(f_idx), .a_valid(a_valid), .a_tag(a_tag),
        .a_target(a_target), .a_taken(a_taken),
        .b_idx(u_idx), .b_valid(b_valid), .b_tag(b_tag),
        .wr_op(op), .wr_idx(u_idx), .wr_tag(u_tag), .wr_target(req.target)
    );

    btb_update_ctl #(.TAG_W(TAG_W)) u_upd (
        .req(req), .req_tag(u_tag),
        .ent_valid(b_valid), .ent_tag(b_tag), .op(op)
    );

    btb_lookup #(.TAG_W(TAG_W)) u_look (
        .pc(fetch_pc), .pc_tag(f_tag),
        .ent_valid(a_valid), .ent_tag(a_tag),
        .ent_target(a_target), .ent_taken(a_taken),
        .redirect(pred_taken), .next_pc(pred_next_pc)
    );
endmodule

// File: rtl/btb_checks.sv
module btb_checks #(
    parameter int IDX_W = 6
) (
    input logic        clk,
    input logic        rst,
    input logic [31:0] fetch_pc,
    input logic        upd_valid,
    input logic [31:0] upd_pc,
    input logic        upd_taken,
    input logic [31:0] upd_target,
    input logic        pred_taken,
    input logic [31:0] pred_next_pc
);
    // R1: the cycle after reset nothing redirects
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> !pred_taken);

    // R5: no redirect means sequential fall-through
    p_fallthrough_r5: assert property (@(posedge clk) disable iff (rst)
        !pred_taken |-> (pred_next_pc == fetch_pc + 32'd4));

    // R6: a taken resolve is visible the next cycle for the same word address
    p_install_r6: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken) |=>
        ((fetch_pc[31:2] == $past(upd_pc[31:2])) ->
         (pred_taken && pred_next_pc == $past(upd_target))));

    // R7: a not-taken resolve leaves that PC without a redirect
    p_drop_taken_r7: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_taken) |=>
        ((fetch_pc[31:2] == $past(upd_pc[31:2])) -> !pred_taken));

    // R10: with no update, a repeated lookup repeats its answer
    p_quiet_table_r10: assert property (@(posedge clk) disable iff (rst)
        (!upd_valid && !rst) |=>
        ($stable(fetch_pc) -> ($stable(pred_taken) && $stable(pred_next_pc))));
endmodule

bind btb btb_checks #(.IDX_W(IDX_W)) u_checks (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .pred_taken(pred_taken), .pred_next_pc(pred_next_pc)
);

// File: tb/tb_btb.sv
`timescale 1ns/1ps
module tb_btb;
    localparam int IW = 3;
    localparam int N  = 1 << IW;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] fetch_pc, upd_pc, upd_target;
    logic        upd_valid, upd_taken;
    logic        pred_taken;
    logic [31:0] pred_next_pc;

    always #2 clk = ~clk;

    btb #(.IDX_W(IW)) dut (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target), .pred_taken(pred_taken), .pred_next_pc(pred_next_pc)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bit          mv  [N];
    logic [31:0] mtag[N];
    logic [31:0] mtgt[N];
    bit          mtk [N];

    function automatic int idx_of(input logic [31:0] pc);
        return int'(pc[IW+1:2]);
    endfunction
    function automatic logic [31:0] tag_of(input logic [31:0] pc);
        return pc >> (IW + 2);
    endfunction

    task automatic expect_of(input logic [31:0] pc, output bit t, output logic [31:0] n);
        int i;
        i = idx_of(pc);
        t = mv[i] && (mtag[i] == tag_of(pc)) && mtk[i];
        n = t ? mtgt[i] : pc + 32'd4;
    endtask

    task automatic compare(input string req, input logic [31:0] pc, input bit et, input logic [31:0] en);
        checks++;
        if (pred_taken !== et || pred_next_pc !== en) begin
            fails++;
            $display("FAIL %s pc=%h got taken=%0b next=%h expected taken=%0b next=%h",
                     req, pc, pred_taken, pred_next_pc, et, en);
        end
    endtask

    task automatic look(input string req, input logic [31:0] pc);
        bit et;
        logic [31:0] en;
        expect_of(pc, et, en);
        fetch_pc = pc;
        #1;
        compare(req, pc, et, en);
    endtask

    task automatic model_write(input logic [31:0] pc, input bit tk, input logic [31:0] tgt);
        int i;
        i = idx_of(pc);
        if (tk) begin
            mv[i] = 1; mtag[i] = tag_of(pc); mtgt[i] = tgt; mtk[i] = 1;
        end else if (mv[i] && mtag[i] == tag_of(pc)) begin
            mtk[i] = 0;
        end
    endtask

    task automatic resolve(input logic [31:0] pc, input bit tk, input logic [31:0] tgt);
        @(negedge clk);
        upd_valid = 1; upd_pc = pc; upd_taken = tk; upd_target = tgt;
        @(negedge clk);
        upd_valid = 0;
        model_write(pc, tk, tgt);
    endtask

    task automatic clear_model();
        for (int i = 0; i < N; i++) begin
            mv[i] = 0; mtk[i] = 0; mtag[i] = '0; mtgt[i] = '0;
        end
    endtask

    initial begin
        rst = 1; upd_valid = 0; upd_pc = '0; upd_taken = 0; upd_target = '0; fetch_pc = '0;
        clear_model();
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: all entries empty after reset
        for (int i = 0; i < N; i++) look("R1", 32'h0000_1000 + 32'(i * 4));
        // R5: miss at the wrap of the address space
        look("R5", 32'hFFFF_FFFC);

        // R6 / R4: install a taken branch in every entry
        for (int i = 0; i < N; i++)
            resolve(32'h0000_4000 + 32'(i * 4), 1, 32'h8000_0000 + 32'(i * 32'h0000_0140));
        for (int i = 0; i < N; i++) look("R4", 32'h0000_4000 + 32'(i * 4));

        // R3: byte offset ignored
        for (int i = 0; i < N; i++)
            for (int b = 1; b < 4; b++) look("R3", 32'h0000_4000 + 32'(i * 4 + b));

        // R2: same index, other tag
        for (int i = 0; i < N; i++) look("R2", 32'h0000_4000 + 32'(i * 4) + 32'(N * 4));
        for (int i = 0; i < N; i++) look("R2", 32'h8000_4000 + 32'(i * 4));

        // R10: garbage on update fields while not valid
        @(negedge clk);
        upd_pc = 32'h0000_4004; upd_taken = 1; upd_target = 32'hDEAD_BEEC;
        repeat (2) @(negedge clk);
        upd_taken = 0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < N; i++) look("R10", 32'h0000_4000 + 32'(i * 4));

        // R7: not-taken resolve of even entries
        for (int i = 0; i < N; i += 2) resolve(32'h0000_4000 + 32'(i * 4), 0, 32'h0);
        for (int i = 0; i < N; i++) look("R7", 32'h0000_4000 + 32'(i * 4));

        // R8: not-taken resolve of alias PCs on odd entries
        for (int i = 1; i < N; i += 2) resolve(32'h0001_4000 + 32'(i * 4), 0, 32'h0);
        for (int i = 1; i < N; i += 2) look("R8", 32'h0000_4000 + 32'(i * 4));

        // R6: alias overwrite of entry 1
        resolve(32'h0002_4004, 1, 32'h0000_9000);
        look("R6", 32'h0000_4004);
        look("R6", 32'h0002_4004);
        // R6: re-install after taken bit was cleared
        resolve(32'h0000_4000, 1, 32'h0000_A000);
        look("R6", 32'h0000_4000);

        // R9: write and lookup of the same entry in one cycle
        begin
            bit et;
            logic [31:0] en;
            @(negedge clk);
            fetch_pc = 32'h0000_4008;
            expect_of(fetch_pc, et, en);
            upd_valid = 1; upd_pc = 32'h0000_4008; upd_taken = 1; upd_target = 32'h0000_B000;
            #1;
            compare("R9", fetch_pc, et, en);
            @(negedge clk);
            upd_valid = 0;
            model_write(32'h0000_4008, 1, 32'h0000_B000);
            look("R9", 32'h0000_4008);
            @(negedge clk);
            fetch_pc = 32'h0000_4008;
            expect_of(fetch_pc, et, en);
            upd_valid = 1; upd_pc = 32'h0000_4008; upd_taken = 0;
            #1;
            compare("R9", fetch_pc, et, en);
            @(negedge clk);
            upd_valid = 0;
            model_write(32'h0000_4008, 0, 32'h0);
            look("R9", 32'h0000_4008);
        end

        // R1: reset in the middle of the run
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        clear_model();
        for (int i = 0; i < N; i++) look("R1", 32'h0000_4000 + 32'(i * 4));
        look("R1", 32'h0002_4004);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog expired before the sequence completed");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule